// File: doc/BRIEF.md
# Edge-Selectable Multi-Channel Timer Capture

This block runs a free-running 16-bit timer and offers four capture channels. Each channel watches its own asynchronous input. When an enabled edge appears on that input, the channel copies the current timer value into its private capture register and raises a sticky flag. The timer also raises two sticky overflow flags: one for a carry out of its low byte and one for a wrap of the full 16-bit word.

Software sets up the block through a simple register port. That port has a write strobe with an address and data, and a separate combinational read address with read data. A single edge-select byte holds a rising-edge enable and a falling-edge enable for each channel. Software clears flags by writing 0 to their bit positions. A per-flag mask decides which set flags drive the single interrupt request output.

The register map is: address 0 holds the edge-select byte, address 1 the flags, address 2 the interrupt mask, and address 3 the live timer (read only). Addresses 4 to 7 hold the capture registers of channels 0 to 3 (read only). Unused upper read bits return 0.

Top module: `edge_capture_timer`

## Requirements
- R1: After reset, the edge-select byte, flags, mask, timer and all capture registers read 0 and irq_o is low.
- R2: The timer increases by one on every clock and wraps from FFFFh to 0000h. Reading address 3 returns its current value.
- R3: Edge-select bit 2n enables capture on a rising edge of cap_i[n]. The capture register holds the timer value of the clock in which the synchronized edge is seen. That value is the timer value at the input change plus 2. The capture register and flag update on the third rising clock after the input change.
- R4: Edge-select bit 2n+1 enables capture on a falling edge of cap_i[n].
- R5: With both bits of a channel set, the channel captures on either edge. An edge whose enable bit is 0 changes neither the capture register nor the flag.
- R6: The flags register holds channel n's capture flag in bit n, the byte overflow flag in bit 4 and the word overflow flag in bit 5. Each flag stays set until a write to address 1 has a 0 in its bit. A 1 in the written bit leaves the flag unchanged.
- R7: The byte overflow flag is set on the clock in which the timer's low byte rolls from FFh to 00h.
- R8: The word overflow flag is set on the clock in which the timer rolls from FFFFh to 0000h.
- R9: irq_o is high exactly when a flag and the mask bit at the same position (address 2, same layout as the flags) are both 1.
- R10: If a capture and a software clear hit the same channel flag in the same clock, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 16 | Register read data, combinational |
| cap_i | input | 4 | Asynchronous capture inputs, one per channel |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that a software clear and a hardware event are the only ways a flag can change. They also assume that the capture inputs only reach the channel logic through the synchronizer. The bench therefore changes each capture input on a falling clock edge and holds every level for several clocks, so each toggle produces exactly one detected edge. It also issues register writes one at a time, each lasting a single clock, and schedules one clear exactly onto the clock of a capture to exercise the set-over-clear rule.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int NUM_CH      = 4;
  localparam int TIMER_W     = 16;
  localparam int SYNC_STAGES = 2;
  localparam int ADDR_W      = $clog2(4 + NUM_CH);
  localparam int EDGE_W      = 2 * NUM_CH;
  localparam int FLAG_W      = NUM_CH + 2;
  localparam int BYTE_BIT    = NUM_CH;
  localparam int WORD_BIT    = NUM_CH + 1;

  localparam logic [ADDR_W-1:0] ADDR_EDGE  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_FLAG  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_MASK  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ADDR_TIMER = ADDR_W'(3);
  localparam int                CAP_BASE   = 4;
endpackage

// File: rtl/cap_timer.sv
module cap_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] cnt_o,
  output logic         byte_carry_o,
  output logic         word_carry_o
);
  localparam int BYTE_W = 8;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o        = cnt_q;
  // carry out of the low byte / of the full word on the next increment
  assign byte_carry_o = &cnt_q[BYTE_W-1:0];
  assign word_carry_o = &cnt_q;

  AST_TIMER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cnt_q == $past(cnt_q) + W'(1)); // R2
endmodule

// File: rtl/cap_edge_sync.sv
module cap_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              lvl;

  assign lvl = sync_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], in_i};
      prev_q <= lvl;
    end
  end

  assign rise_o = lvl & ~prev_q;
  assign fall_o = ~lvl & prev_q;
endmodule

// File: rtl/cap_channel.sv
module cap_channel #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rise_i,
  input  logic         fall_i,
  input  logic         en_rise_i,
  input  logic         en_fall_i,
  input  logic [W-1:0] timer_i,
  input  logic         clr_i,
  output logic [W-1:0] cap_o,
  output logic         flag_o
);
  logic [W-1:0] cap_q;
  logic         flag_q;
  logic         stb;

  assign stb = (rise_i & en_rise_i) | (fall_i & en_fall_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (stb) cap_q <= timer_i;
      // set has priority over software clear
      if (stb)        flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign cap_o  = cap_q;
  assign flag_o = flag_q;

  AST_CAP_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb |=> cap_q == $past(timer_i)); // R3
  AST_CAP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb && clr_i) |=> flag_q); // R10
  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !stb) |=> !flag_q); // R6
  AST_FLAG_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(stb)); // R5
  AST_CAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb |=> $stable(cap_q)); // R5
endmodule

// File: rtl/edge_capture_timer.sv
module edge_capture_timer
  import cap_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [TIMER_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [TIMER_W-1:0] rd_data_o,
  input  logic [NUM_CH-1:0]  cap_i,
  output logic               irq_o
);
  logic [TIMER_W-1:0] timer;
  logic               byte_carry, word_carry;
  logic [EDGE_W-1:0]  edge_q;
  logic [FLAG_W-1:0]  mask_q;
  logic               byte_q, word_q;
  logic [NUM_CH-1:0]  ch_flag;
  logic [FLAG_W-1:0]  flags;
  logic [TIMER_W-1:0] cap_val [NUM_CH];
  logic               flag_wr;
  logic               unused_wdata;

  assign unused_wdata = ^wr_data_i[TIMER_W-1:EDGE_W];
  assign flag_wr      = wr_en_i && (wr_addr_i == ADDR_FLAG);

  cap_timer #(.W(TIMER_W)) i_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cnt_o        (timer),
    .byte_carry_o (byte_carry),
    .word_carry_o (word_carry)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic rise, fall;

    cap_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .in_i   (cap_i[n]),
      .rise_o (rise),
      .fall_o (fall)
    );

    cap_channel #(.W(TIMER_W)) i_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rise_i    (rise),
      .fall_i    (fall),
      .en_rise_i (edge_q[2*n]),
      .en_fall_i (edge_q[2*n+1]),
      .timer_i   (timer),
      .clr_i     (flag_wr && !wr_data_i[n]),
      .cap_o     (cap_val[n]),
      .flag_o    (ch_flag[n])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_q <= '0;
      mask_q <= '0;
      byte_q <= 1'b0;
      word_q <= 1'b0;
    end else begin
      if (wr_en_i && wr_addr_i == ADDR_EDGE) edge_q <= wr_data_i[EDGE_W-1:0];
      if (wr_en_i && wr_addr_i == ADDR_MASK) mask_q <= wr_data_i[FLAG_W-1:0];
      if (byte_carry)                              byte_q <= 1'b1;
      else if (flag_wr && !wr_data_i[BYTE_BIT])    byte_q <= 1'b0;
      if (word_carry)                              word_q <= 1'b1;
      else if (flag_wr && !wr_data_i[WORD_BIT])    word_q <= 1'b0;
    end
  end

  assign flags = {word_q, byte_q, ch_flag};
  assign irq_o = |(flags & mask_q);

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      ADDR_EDGE:  rd_data_o[EDGE_W-1:0] = edge_q;
      ADDR_FLAG:  rd_data_o[FLAG_W-1:0] = flags;
      ADDR_MASK:  rd_data_o[FLAG_W-1:0] = mask_q;
      ADDR_TIMER: rd_data_o             = timer;
      default: begin
        for (int n = 0; n < NUM_CH; n++)
          if (rd_addr_i == ADDR_W'(CAP_BASE + n)) rd_data_o = cap_val[n];
      end
    endcase
  end

  AST_BYTE_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_carry |=> byte_q); // R7
  AST_WORD_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timer == '1) |=> word_q && (timer == '0)); // R8
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o); // R9
endmodule

// File: tb/test_edge_capture_timer.sv
`timescale 1ns/1ps
module test_edge_capture_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [3:0]  cap_r = '0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int pending = 0;
  bit done = 0;

  typedef struct {
    string       req;
    bit          is_irq;
    logic [2:0]  addr;
    logic [15:0] exp;
    logic [15:0] msk;
  } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;

  edge_capture_timer i_edge_capture_timer (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .cap_i     (cap_r),
    .irq_o     (irq)
  );

  // monitor: pops expected items and compares against the port
  initial begin
    item_t it;
    logic [15:0] got;
    forever begin
      wait (q.size() > 0);
      it = q.pop_front();
      rd_addr = it.addr;
      #1;
      got = it.is_irq ? {15'd0, irq} : rd_data;
      checks++;
      if ((got & it.msk) !== (it.exp & it.msk)) begin
        fails++;
        $display("FAIL %s addr=%0d got=%h expected=%h", it.req, it.addr,
                 got & it.msk, it.exp & it.msk);
      end
      pending--;
    end
  end

  task automatic expect_reg(string req, logic [2:0] a, logic [15:0] e,
                            logic [15:0] m = 16'hFFFF);
    item_t it;
    it.req = req; it.is_irq = 0; it.addr = a; it.exp = e; it.msk = m;
    pending++;
    q.push_back(it);
    wait (pending == 0);
  endtask

  task automatic expect_irq(string req, bit e);
    item_t it;
    it.req = req; it.is_irq = 1; it.addr = 3'd0; it.exp = {15'd0, e}; it.msk = 16'h0001;
    pending++;
    q.push_back(it);
    wait (pending == 0);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drive(int ch, bit v, output logic [15:0] e);
    cap_r[ch] = v;
    e = 16'((cyc + 2) % 65536);
  endtask

  initial begin
    logic [15:0] e0, e1, e2, e3;
    step(3);
    // R1: reset state
    for (int a = 0; a < 8; a++) expect_reg("R1 reset", 3'(a), 16'h0000);
    expect_irq("R1 irq reset", 1'b0);
    rst_n = 1'b1;
    step(5);
    expect_reg("R2 timer count", 3'd3, 16'(cyc));
    step(7);
    expect_reg("R2 timer count", 3'd3, 16'(cyc));

    // R5: disabled edge ignored
    drive(0, 1'b1, e0);
    step(5);
    expect_reg("R5 no capture when disabled", 3'd4, 16'h0000);
    expect_reg("R5 no flag when disabled", 3'd1, 16'h0000, 16'h000F);

    // ch0 rise, ch1 fall, ch2 both, ch3 rise
    wr(3'd0, 16'h0079);
    expect_reg("R11 edge select readback", 3'd0, 16'h0079);
    drive(0, 1'b0, e0);
    step(5);
    expect_reg("R3 falling ignored on rise-only channel", 3'd1, 16'h0000, 16'h000F);

    // R3: rising capture with exact latency
    drive(0, 1'b1, e0);
    step(2);
    expect_reg("R3 not yet captured", 3'd4, 16'h0000);
    step(1);
    expect_reg("R3 capture value", 3'd4, e0);
    expect_reg("R3 flag set", 3'd1, 16'h0001, 16'h000F);

    // R6: write 1 keeps, write 0 clears
    wr(3'd1, 16'h003F);
    expect_reg("R6 write one keeps flag", 3'd1, 16'h0001, 16'h000F);
    // R9: mask gating
    expect_irq("R9 masked off", 1'b0);
    wr(3'd2, 16'h0001);
    expect_irq("R9 mask on", 1'b1);
    wr(3'd1, 16'h003E);
    expect_reg("R6 write zero clears", 3'd1, 16'h0000, 16'h000F);
    expect_irq("R9 cleared flag", 1'b0);

    // R4: falling capture on ch1
    drive(1, 1'b1, e1);
    step(5);
    expect_reg("R4 rise ignored on fall-only", 3'd1, 16'h0000, 16'h000F);
    drive(1, 1'b0, e1);
    step(5);
    expect_reg("R4 falling capture value", 3'd5, e1);
    expect_reg("R4 flag", 3'd1, 16'h0002, 16'h000F);
    wr(3'd1, 16'h0000);

    // R5: both edges on ch2
    drive(2, 1'b1, e2);
    step(5);
    expect_reg("R5 both: rise capture", 3'd6, e2);
    wr(3'd1, 16'h0000);
    step(3);
    drive(2, 1'b0, e2);
    step(5);
    expect_reg("R5 both: fall capture", 3'd6, e2);
    expect_reg("R5 both: flag", 3'd1, 16'h0004, 16'h000F);
    wr(3'd1, 16'h0000);

    // ch3 rise only: falling leaves register
    drive(3, 1'b1, e3);
    step(5);
    expect_reg("R3 ch3 rise capture", 3'd7, e3);
    wr(3'd1, 16'h0000);
    drive(3, 1'b0, e1);
    step(5);
    expect_reg("R5 ch3 fall keeps register", 3'd7, e3);
    expect_reg("R5 ch3 fall keeps flag", 3'd1, 16'h0000, 16'h000F);

    // R10: capture beats same-cycle clear
    drive(0, 1'b0, e1);
    step(5);
    drive(0, 1'b1, e0);
    step(2);
    wr(3'd1, 16'h0000);
    expect_reg("R10 capture wins value", 3'd4, e0);
    expect_reg("R10 capture wins flag", 3'd1, 16'h0001, 16'h000F);

    // R7: byte overflow
    while (cyc % 256 != 16) step(1);
    wr(3'd1, 16'h0000);
    expect_reg("R7 byte flag cleared", 3'd1, 16'h0000, 16'h0010);
    while (cyc % 256 != 255) step(1);
    expect_reg("R7 byte flag before carry", 3'd1, 16'h0000, 16'h0010);
    step(1);
    expect_reg("R7 byte flag after carry", 3'd1, 16'h0010, 16'h0010);
    wr(3'd2, 16'h0010);
    expect_irq("R9 byte flag irq", 1'b1);
    wr(3'd2, 16'h0000);

    // R8: word overflow
    while (cyc != 65535) step(1);
    expect_reg("R8 word flag before wrap", 3'd1, 16'h0000, 16'h0020);
    expect_reg("R2 timer at max", 3'd3, 16'hFFFF);
    step(1);
    expect_reg("R8 word flag after wrap", 3'd1, 16'h0020, 16'h0020);
    expect_reg("R2 timer wrapped", 3'd3, 16'h0000);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule